// File: doc/BRIEF.md
# Touch Key Detection Filter

This block turns raw capacitive key measurements into clean per-key touch decisions. Once per acquisition cycle, marked by a one-clock strobe, it compares each key's measured signal with a reference value that it tracks itself. A touch pulls the signal below the reference. A key is declared touched only after the touch condition has held on a programmed number of consecutive cycles. It is declared released only after the release condition has held on a second, separately chosen number of cycles. While a key is touched its release level is relaxed by one eighth of the threshold, which gives it hysteresis.

References follow slow environmental change. They drift toward touch slowly and away from touch faster. Drift stops on every key while any key is touched, and for a hold-off window after the last release. Two guards keep a key from being stuck. A key held in detect longer than a programmed limit is recalibrated: only that key, or every key, depending on a scope input. A signal that jumps away from touch by more than a small margin recalibrates that key at once. Full calibration runs after reset and after an all-key max-on event. During full calibration the calibrate flag is high and all detect bits are clear.

A global state machine has two states: CALIBRATE and RUN. Its transitions are *cal_done*, taken after the last calibration strobe, and *stuck_all*, taken on a max-on event when the scope input is clear. Each key has a four-state machine:

- IDLE goes to FILTER_IN on *touch_seen*.
- FILTER_IN goes back to IDLE on *touch_lost*, or on to DETECT on *entry_met*.
- DETECT goes to FILTER_OUT on *release_seen*.
- FILTER_OUT goes back to DETECT on *release_lost*, or to IDLE on *exit_met*.
- Any state goes to IDLE on *key_recal*.

Top module: `tkd_top`

## Requirements
- R1: After reset the block is in CALIBRATE, with `cal_o`=1 and all detect bits 0. On each strobe in CALIBRATE every reference is loaded with its key's signal. After CAL_STROBES strobes the block enters RUN and `cal_o` drops to 0.
- R2: A key enters detect on the strobe where the touch condition, reference minus signal being at least the threshold, has held on the programmed number of consecutive strobes. A DI setting of 0 or 1 counts as 2. A strobe without the touch condition restarts the count.
- R3: A threshold setting of 0 acts as 1, so a signal equal to the reference never detects.
- R4: While a key is in detect, its release level is the effective threshold minus the effective threshold shifted right by 3. The key stays in detect while reference minus signal is at least that level.
- R5: A key leaves detect after the release condition has held on consecutive strobes. The count is 4 when `fast_out_i`=1; otherwise it is the effective DI. A strobe with the key back above the release level returns it to DETECT and restarts the count.
- R6: `detect_o[k]` is 1 while key k is in DETECT or FILTER_OUT, and `touch_o` is the OR of all detect bits.
- R7: Reference drift is counted in periods of DRIFT_BASE strobes. Every TOWARD_PER periods, each idle key whose signal is below its reference lowers that reference by 1. Every AWAY_PER periods, each idle key whose signal is above its reference raises that reference by 1.
- R8: The drift period counters stop while any key is in detect. They stay stopped for HOLD_STROBES strobes after the strobe on which the last key left detect.
- R9: When `maxon_i` is nonzero and a key has been in detect for `maxon_i`×MAXON_STEP strobes, and `recal_one_i`=1, only that key is recalibrated. Its reference is loaded with its signal and it returns to IDLE.
- R10: When the max-on condition of R9 is met with `recal_one_i`=0, every key is recalibrated and the block enters CALIBRATE.
- R11: A signal greater than its reference plus POS_MARGIN (4) recalibrates that key on that strobe, whatever its state.
- R12: While `cal_o`=1 all detect bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-clock pulse per acquisition cycle |
| sig_i | input | NKEYS*SIG_W | Measured signal; key k at bits [k*SIG_W +: SIG_W] |
| thr_i | input | NKEYS*CFG_W | Detect threshold per key |
| di_i | input | NKEYS*CFG_W | Entry integrator count per key |
| fast_out_i | input | 1 | Release after 4 cycles instead of the DI count |
| maxon_i | input | CFG_W | Max-on limit in units of MAXON_STEP strobes; 0 disables it |
| recal_one_i | input | 1 | 1 recalibrates only the stuck key; 0 recalibrates all keys |
| detect_o | output | NKEYS | Per-key detect bits |
| touch_o | output | 1 | Any key in detect |
| cal_o | output | 1 | Full calibration in progress |
| ref_o | output | NKEYS*SIG_W | Per-key reference values |

## Verification
The bench builds the block with three keys and two calibration strobes. It shrinks the timing parameters: a drift period of 2 strobes, toward and away rates of 3 and 2 periods, a hold-off of 5 strobes and a max-on step of 2 strobes. With these values, drift ticks, the end of the hold-off window and both max-on scopes are all reached within a few dozen strobes. Directed phases then cover entry and exit integration, DI and threshold substitution, hysteresis and inverted-signal recalibration. A long pseudo-random phase, with the configuration changing as it runs, exercises the interplay of these behaviours against the bench's own model.

// File: rtl/tkd_pkg.sv
package tkd_pkg;

    typedef enum logic [1:0] {
        K_IDLE     = 2'd0,
        K_ENTER    = 2'd1,
        K_DETECT   = 2'd2,
        K_EXIT     = 2'd3
    } key_state_e;

    typedef enum logic {
        G_CAL = 1'b0,
        G_RUN = 1'b1
    } glob_state_e;

endpackage

// File: rtl/tkd_drift_sched.sv
module tkd_drift_sched #(
    parameter int DRIFT_BASE   = 20,
    parameter int TOWARD_PER   = 18,
    parameter int AWAY_PER     = 6,
    parameter int HOLD_STROBES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic run_i,
    input  logic any_det_i,
    output logic tow_tick_o,
    output logic away_tick_o
);
    localparam int BW = (DRIFT_BASE   > 1) ? $clog2(DRIFT_BASE)   : 1;
    localparam int TW = (TOWARD_PER   > 1) ? $clog2(TOWARD_PER)   : 1;
    localparam int AW = (AWAY_PER     > 1) ? $clog2(AWAY_PER)     : 1;
    localparam int HW = $clog2(HOLD_STROBES + 1);

    logic [BW-1:0] base_q;
    logic [TW-1:0] tow_q;
    logic [AW-1:0] away_q;
    logic [HW-1:0] hold_q;
    logic          frozen;
    logic          advance;
    logic          period_end;
    logic          tow_last;
    logic          away_last;

    assign frozen     = any_det_i || (hold_q != '0);
    assign advance    = strobe_i && run_i && !frozen;
    assign period_end = (base_q == BW'(DRIFT_BASE - 1));
    assign tow_last   = (tow_q  == TW'(TOWARD_PER - 1));
    assign away_last  = (away_q == AW'(AWAY_PER - 1));

    assign tow_tick_o  = advance && period_end && tow_last;
    assign away_tick_o = advance && period_end && away_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            tow_q  <= '0;
            away_q <= '0;
            hold_q <= '0;
        end else if (strobe_i) begin
            if (!run_i) begin
                base_q <= '0;
                tow_q  <= '0;
                away_q <= '0;
                hold_q <= '0;
            end else begin
                if (!frozen) begin
                    if (period_end) begin
                        base_q <= '0;
                        tow_q  <= tow_last  ? '0 : tow_q  + TW'(1);
                        away_q <= away_last ? '0 : away_q + AW'(1);
                    end else begin
                        base_q <= base_q + BW'(1);
                    end
                end
                if (any_det_i)
                    hold_q <= HW'(HOLD_STROBES);
                else if (hold_q != '0)
                    hold_q <= hold_q - HW'(1);
            end
        end
    end

    // R8: the last release always starts a full hold-off window
    a_r8_hold_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_det_i) |-> (hold_q == HW'(HOLD_STROBES)));

    // R8: no drift tick is issued while any key sits in detect
    a_r8_no_tick_in_detect: assert property (@(posedge clk) disable iff (!rst_n)
        any_det_i |-> !(tow_tick_o || away_tick_o));

endmodule

// File: rtl/tkd_key_chan.sv
module tkd_key_chan
    import tkd_pkg::*;
#(
    parameter int SIG_W      = 16,
    parameter int CFG_W      = 8,
    parameter int MAXON_STEP = 20,
    parameter int POS_MARGIN = 4,
    parameter int HYS_SHIFT  = 3,
    parameter int FAST_OUT_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             load_all_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic [CFG_W-1:0] thr_i,
    input  logic [CFG_W-1:0] di_i,
    input  logic             fast_out_i,
    input  logic [CFG_W-1:0] maxon_i,
    input  logic             recal_one_i,
    input  logic             tow_tick_i,
    input  logic             away_tick_i,
    output logic             maxon_hit_o,
    output logic             detect_o,
    output logic [SIG_W-1:0] ref_o
);
    localparam int TMAX  = ((1 << CFG_W) - 1) * MAXON_STEP;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam int SW2   = SIG_W + 2;

    key_state_e       st_q, st_n;
    logic [CFG_W-1:0] cnt_q, cnt_n;
    logic [TMR_W-1:0] tmr_q, tmr_n;
    logic [SIG_W-1:0] ref_q, ref_n;

    logic [CFG_W-1:0] thr_e, hys, di_e, ex_n;
    logic [CFG_W:0]   cnt_inc;
    logic [TMR_W:0]   tmr_inc;
    logic [TMR_W:0]   limit;
    logic [SW2-1:0]   sig_w, ref_w;
    logic             touch_lvl, hold_lvl, pos_recal, in_det, hit, local_recal;

    assign thr_e   = (thr_i == '0) ? CFG_W'(1) : thr_i;
    assign hys     = thr_e - (thr_e >> HYS_SHIFT);
    assign di_e    = (di_i < CFG_W'(2)) ? CFG_W'(2) : di_i;
    assign ex_n    = fast_out_i ? CFG_W'(FAST_OUT_N) : di_e;
    assign cnt_inc = {1'b0, cnt_q} + (CFG_W+1)'(1);
    assign tmr_inc = {1'b0, tmr_q} + (TMR_W+1)'(1);
    assign limit   = (TMR_W+1)'(maxon_i) * (TMR_W+1)'(MAXON_STEP);

    assign sig_w     = SW2'(sig_i);
    assign ref_w     = SW2'(ref_q);
    assign touch_lvl = ref_w >= sig_w + SW2'(thr_e);
    assign hold_lvl  = ref_w >= sig_w + SW2'(hys);
    assign pos_recal = sig_w > ref_w + SW2'(POS_MARGIN);

    assign in_det      = (st_q == K_DETECT) || (st_q == K_EXIT);
    assign hit         = in_det && (maxon_i != '0) && (tmr_inc >= limit);
    assign local_recal = pos_recal || (hit && recal_one_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= K_IDLE;
            cnt_q <= '0;
            tmr_q <= '0;
            ref_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            tmr_q <= tmr_n;
            ref_q <= ref_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        tmr_n = tmr_q;
        ref_n = ref_q;
        if (load_all_i || (strobe_i && local_recal)) begin
            st_n  = K_IDLE;          // key_recal
            cnt_n = '0;
            tmr_n = '0;
            ref_n = sig_i;
        end else if (strobe_i) begin
            if (in_det && (tmr_q != TMR_W'(TMAX)))
                tmr_n = tmr_inc[TMR_W-1:0];
            unique case (st_q)
                K_IDLE: begin
                    if (touch_lvl) begin
                        st_n  = K_ENTER;   // touch_seen
                        cnt_n = CFG_W'(1);
                    end else if (tow_tick_i && (sig_i < ref_q)) begin
                        ref_n = ref_q - SIG_W'(1);
                    end else if (away_tick_i && (sig_i > ref_q)) begin
                        ref_n = ref_q + SIG_W'(1);
                    end
                end
                K_ENTER: begin
                    if (!touch_lvl) begin
                        st_n  = K_IDLE;    // touch_lost
                        cnt_n = '0;
                    end else if (cnt_inc >= {1'b0, di_e}) begin
                        st_n  = K_DETECT;  // entry_met
                        cnt_n = '0;
                        tmr_n = '0;
                    end else begin
                        cnt_n = cnt_inc[CFG_W-1:0];
                    end
                end
                K_DETECT: begin
                    if (!hold_lvl) begin
                        st_n  = K_EXIT;    // release_seen
                        cnt_n = CFG_W'(1);
                    end
                end
                K_EXIT: begin
                    if (hold_lvl) begin
                        st_n  = K_DETECT;  // release_lost
                        cnt_n = '0;
                    end else if (cnt_inc >= {1'b0, ex_n}) begin
                        st_n  = K_IDLE;    // exit_met
                        cnt_n = '0;
                        tmr_n = '0;
                    end else begin
                        cnt_n = cnt_inc[CFG_W-1:0];
                    end
                end
                default: st_n = K_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        detect_o    = in_det;
        maxon_hit_o = hit;
        ref_o       = ref_q;
    end

    // R2: detect can only be entered from the entry filter
    a_r2_enter_via_filter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detect_o) |-> ($past(st_q) == K_ENTER));

    // R5: detect ends only through the exit filter or a recalibration
    a_r5_exit_via_filter: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(detect_o) |-> ($past(st_q) == K_EXIT || $past(load_all_i) || $past(local_recal)));

    // R11: an inverted jump reloads the reference and drops detect
    a_r11_pos_recal: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && pos_recal) |=> (ref_q == $past(sig_i)) && !detect_o);

    // R12: a full-calibration load clears detect and captures the signal
    a_r12_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load_all_i |=> !detect_o && (ref_q == $past(sig_i)));

    // R4: a key in detect with the signal at or past the release level stays in detect
    a_r4_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !load_all_i && !local_recal && st_q == K_DETECT && hold_lvl) |=> detect_o);

endmodule

// File: rtl/tkd_top.sv
module tkd_top
    import tkd_pkg::*;
#(
    parameter int NKEYS        = 7,
    parameter int SIG_W        = 16,
    parameter int CFG_W        = 8,
    parameter int CAL_STROBES  = 4,
    parameter int DRIFT_BASE   = 20,
    parameter int TOWARD_PER   = 18,
    parameter int AWAY_PER     = 6,
    parameter int HOLD_STROBES = 500,
    parameter int MAXON_STEP   = 20,
    parameter int POS_MARGIN   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe_i,
    input  logic [NKEYS*SIG_W-1:0] sig_i,
    input  logic [NKEYS*CFG_W-1:0] thr_i,
    input  logic [NKEYS*CFG_W-1:0] di_i,
    input  logic                   fast_out_i,
    input  logic [CFG_W-1:0]       maxon_i,
    input  logic                   recal_one_i,
    output logic [NKEYS-1:0]       detect_o,
    output logic                   touch_o,
    output logic                   cal_o,
    output logic [NKEYS*SIG_W-1:0] ref_o
);
    localparam int CCW = $clog2(CAL_STROBES + 1);

    glob_state_e      gst_q, gst_n;
    logic [CCW-1:0]   ccnt_q, ccnt_n;
    logic [NKEYS-1:0] hit_vec;
    logic [NKEYS-1:0] det_vec;
    logic             glob_hit;
    logic             load_all;
    logic             tow_tick, away_tick;

    assign glob_hit = (gst_q == G_RUN) && !recal_one_i && (|hit_vec);
    assign load_all = strobe_i && ((gst_q == G_CAL) || glob_hit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gst_q  <= G_CAL;
            ccnt_q <= '0;
        end else begin
            gst_q  <= gst_n;
            ccnt_q <= ccnt_n;
        end
    end

    // next state
    always_comb begin
        gst_n  = gst_q;
        ccnt_n = ccnt_q;
        unique case (gst_q)
            G_CAL: begin
                if (strobe_i) begin
                    if (ccnt_q == CCW'(CAL_STROBES - 1)) begin
                        gst_n  = G_RUN;   // cal_done
                        ccnt_n = '0;
                    end else begin
                        ccnt_n = ccnt_q + CCW'(1);
                    end
                end
            end
            G_RUN: begin
                if (strobe_i && glob_hit) begin
                    gst_n  = G_CAL;       // stuck_all
                    ccnt_n = '0;
                end
            end
            default: gst_n = G_CAL;
        endcase
    end

    // outputs
    always_comb begin
        cal_o    = (gst_q == G_CAL);
        detect_o = det_vec;
        touch_o  = |det_vec;
    end

    tkd_drift_sched #(
        .DRIFT_BASE  (DRIFT_BASE),
        .TOWARD_PER  (TOWARD_PER),
        .AWAY_PER    (AWAY_PER),
        .HOLD_STROBES(HOLD_STROBES)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (strobe_i),
        .run_i      (gst_q == G_RUN),
        .any_det_i  (|det_vec),
        .tow_tick_o (tow_tick),
        .away_tick_o(away_tick)
    );

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        tkd_key_chan #(
            .SIG_W     (SIG_W),
            .CFG_W     (CFG_W),
            .MAXON_STEP(MAXON_STEP),
            .POS_MARGIN(POS_MARGIN)
        ) u_key (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_i   (strobe_i),
            .load_all_i (load_all),
            .sig_i      (sig_i[k*SIG_W +: SIG_W]),
            .thr_i      (thr_i[k*CFG_W +: CFG_W]),
            .di_i       (di_i[k*CFG_W +: CFG_W]),
            .fast_out_i (fast_out_i),
            .maxon_i    (maxon_i),
            .recal_one_i(recal_one_i),
            .tow_tick_i (tow_tick),
            .away_tick_i(away_tick),
            .maxon_hit_o(hit_vec[k]),
            .detect_o   (det_vec[k]),
            .ref_o      (ref_o[k*SIG_W +: SIG_W])
        );
    end

    // R12: no key reports detect during full calibration
    a_r12_cal_no_detect: assert property (@(posedge clk) disable iff (!rst_n)
        cal_o |-> (detect_o == '0));

    // R10: an all-key max-on event starts full calibration
    a_r10_stuck_all: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !cal_o && !recal_one_i && (|hit_vec)) |=> cal_o);

    // R9: with the single-key scope, the block never leaves RUN
    a_r9_single_scope_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_o && recal_one_i) |=> !cal_o);

    // R1: calibration only ends on a strobe
    a_r1_cal_waits_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_o && !strobe_i) |=> cal_o);

endmodule

// File: tb/tkd_top_bench.sv
module tkd_top_bench;
    localparam int NK   = 3;
    localparam int SW   = 16;
    localparam int CW   = 8;
    localparam int CALN = 2;
    localparam int DB   = 2;
    localparam int TP   = 3;
    localparam int AP   = 2;
    localparam int HOLD = 5;
    localparam int STEP = 2;
    localparam int TMAX = 255 * STEP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic [NK*SW-1:0]  sig_v = '0;
    logic [NK*CW-1:0]  thr_v = '0;
    logic [NK*CW-1:0]  di_v = '0;
    logic              fo = 1'b0;
    logic [CW-1:0]     maxon = '0;
    logic              scope = 1'b0;
    logic [NK-1:0]     det;
    logic              touch;
    logic              cal;
    logic [NK*SW-1:0]  refv;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";
    int unsigned seed = 32'h1234_5678;

    // reference model state
    int mst[NK], mcnt[NK], mtmr[NK], mref[NK];
    int mcal, mcc, mbase, mtow, maway, mhold;

    always #5 clk = ~clk;

    tkd_top #(
        .NKEYS(NK), .SIG_W(SW), .CFG_W(CW), .CAL_STROBES(CALN),
        .DRIFT_BASE(DB), .TOWARD_PER(TP), .AWAY_PER(AP),
        .HOLD_STROBES(HOLD), .MAXON_STEP(STEP), .POS_MARGIN(4)
    ) u_tkd_top (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .sig_i(sig_v),
        .thr_i(thr_v), .di_i(di_v), .fast_out_i(fo), .maxon_i(maxon),
        .recal_one_i(scope), .detect_o(det), .touch_o(touch), .cal_o(cal),
        .ref_o(refv)
    );

    function automatic int sig_of(int k);
        return int'(sig_v[k*SW +: SW]);
    endfunction

    task automatic load_key(int k);
        mref[k] = sig_of(k);
        mst[k] = 0; mcnt[k] = 0; mtmr[k] = 0;
    endtask

    always @(posedge clk) begin : model
        int anyd, hitall, frz, towt, awt, th, hy, di, ex, sg, rf, ind, hk;
        if (!rst_n) begin
            mcal = 1; mcc = 0; mbase = 0; mtow = 0; maway = 0; mhold = 0;
            for (int k = 0; k < NK; k++) begin
                mst[k] = 0; mcnt[k] = 0; mtmr[k] = 0; mref[k] = 0;
            end
        end else if (strobe) begin
            anyd = 0; hitall = 0;
            for (int k = 0; k < NK; k++)
                if (mst[k] >= 2) begin
                    anyd = 1;
                    if (maxon != 0 && mtmr[k] + 1 >= int'(maxon) * STEP && !scope) hitall = 1;
                end
            if (mcal != 0) begin
                for (int k = 0; k < NK; k++) load_key(k);
                mbase = 0; mtow = 0; maway = 0; mhold = 0;
                if (mcc == CALN - 1) begin mcal = 0; mcc = 0; end
                else mcc++;
            end else begin
                frz  = (anyd != 0 || mhold != 0) ? 1 : 0;
                towt = (!frz && mbase == DB - 1 && mtow == TP - 1) ? 1 : 0;
                awt  = (!frz && mbase == DB - 1 && maway == AP - 1) ? 1 : 0;
                if (!frz) begin
                    if (mbase == DB - 1) begin
                        mbase = 0;
                        mtow  = (mtow == TP - 1) ? 0 : mtow + 1;
                        maway = (maway == AP - 1) ? 0 : maway + 1;
                    end else mbase++;
                end
                if (anyd != 0) mhold = HOLD;
                else if (mhold > 0) mhold--;
                if (hitall != 0) begin
                    for (int k = 0; k < NK; k++) load_key(k);
                    mcal = 1; mcc = 0;
                end else begin
                    for (int k = 0; k < NK; k++) begin
                        sg = sig_of(k); rf = mref[k];
                        th = int'(thr_v[k*CW +: CW]); if (th == 0) th = 1;
                        hy = th - th / 8;
                        di = int'(di_v[k*CW +: CW]); if (di < 2) di = 2;
                        ex = fo ? 4 : di;
                        ind = (mst[k] >= 2) ? 1 : 0;
                        hk = (ind != 0 && maxon != 0 && mtmr[k] + 1 >= int'(maxon) * STEP) ? 1 : 0;
                        if (sg > rf + 4 || (hk != 0 && scope)) load_key(k);
                        else begin
                            if (ind != 0 && mtmr[k] < TMAX) mtmr[k]++;
                            case (mst[k])
                                0: if (rf - sg >= th) begin mst[k] = 1; mcnt[k] = 1; end
                                   else if (towt != 0 && sg < rf) mref[k] = rf - 1;
                                   else if (awt != 0 && sg > rf) mref[k] = rf + 1;
                                1: if (rf - sg >= th) begin
                                       if (mcnt[k] + 1 >= di) begin mst[k] = 2; mcnt[k] = 0; mtmr[k] = 0; end
                                       else mcnt[k]++;
                                   end else begin mst[k] = 0; mcnt[k] = 0; end
                                2: if (rf - sg < hy) begin mst[k] = 3; mcnt[k] = 1; end
                                default: if (rf - sg < hy) begin
                                       if (mcnt[k] + 1 >= ex) begin mst[k] = 0; mcnt[k] = 0; mtmr[k] = 0; end
                                       else mcnt[k]++;
                                   end else begin mst[k] = 2; mcnt[k] = 0; end
                            endcase
                        end
                    end
                end
            end
        end
    end

    task automatic check_val(string t, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic compare();
        int ed, any;
        ed = 0; any = 0;
        for (int k = 0; k < NK; k++)
            if (mst[k] >= 2) begin ed |= (1 << k); any = 1; end
        check_val(tag, int'(det), ed, "detect (R6)");
        check_val(tag, int'(touch), any, "touch R6");
        check_val(tag, int'(cal), mcal, "cal R12");
        for (int k = 0; k < NK; k++)
            check_val(tag, int'(refv[k*SW +: SW]), mref[k], $sformatf("ref%0d", k));
    endtask

    task automatic cyc(bit s);
        @(negedge clk);
        if (rst_n) compare();
        strobe = s;
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) begin cyc(1'b1); cyc(1'b0); end
    endtask

    task automatic set_off(int k, int off);
        sig_v[k*SW +: SW] = SW'(mref[k] + off);
    endtask

    task automatic set_cfg(int k, int t, int d);
        thr_v[k*CW +: CW] = CW'(t);
        di_v[k*CW +: CW]  = CW'(d);
    endtask

    function automatic int rnd(int n);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % n);
    endfunction

    initial begin
        for (int k = 0; k < NK; k++) begin
            sig_v[k*SW +: SW] = SW'(1000);
            set_cfg(k, 20, 2);
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        check_val("R1", int'(cal), 1, "cal after reset");
        check_val("R1", int'(det), 0, "detect after reset");
        check_val("R6", int'(touch), 0, "touch after reset");
        rst_n = 1'b1;
        tag = "R1";
        strobes(2);
        cyc(1'b0);
        check_val("R1", int'(cal), 0, "cal after CAL_STROBES");
        for (int k = 0; k < NK; k++)
            check_val("R1", int'(refv[k*SW +: SW]), 1000, "ref captured");

        // R2: entry integrator, DI substitution, restart on miss
        tag = "R2";
        set_cfg(0, 20, 0); set_cfg(1, 20, 5); set_cfg(2, 20, 1);
        set_off(0, -20); set_off(1, -25); set_off(2, 0);
        strobes(4);
        set_off(1, 0); strobes(1);
        set_off(1, -25); strobes(6);

        // R3: threshold zero acts as one
        tag = "R3";
        set_cfg(2, 0, 2);
        set_off(2, 0); strobes(4);
        set_off(2, -1); strobes(3);

        // release everything
        tag = "R5";
        for (int k = 0; k < NK; k++) set_off(k, 0);
        strobes(10);

        // R4: hysteresis (thr 40 -> release level 35)
        tag = "R4";
        set_cfg(0, 40, 2);
        set_off(0, -40); strobes(3);
        set_off(0, -36); strobes(4);
        set_off(0, -35); strobes(3);
        set_off(0, -34); strobes(4);

        // R5: fast-out vs DI exit count
        tag = "R5";
        fo = 1'b1; set_cfg(1, 20, 6);
        set_off(1, -30); strobes(7);
        set_off(1, 0); strobes(2);
        set_off(1, -30); strobes(1);
        set_off(1, 0); strobes(5);
        fo = 1'b0;
        set_off(1, -30); strobes(7);
        set_off(1, 0); strobes(8);

        // R7 / R8: drift after hold-off
        tag = "R8";
        for (int k = 0; k < NK; k++) begin set_cfg(k, 20, 2); set_off(k, 0); end
        strobes(3);
        tag = "R7";
        set_off(0, -5); set_off(1, 3);
        strobes(30);

        // R9: single-key max-on recalibration
        tag = "R9";
        maxon = CW'(2); scope = 1'b1;
        set_off(0, -25); set_off(1, 0);
        strobes(10);

        // R10: all-key max-on recalibration, R12 calibration clears detect
        tag = "R10";
        scope = 1'b0;
        set_off(1, -25); set_off(2, -25);
        strobes(3);
        tag = "R12";
        strobes(7);
        maxon = '0;

        // R11: inverted jump recalibration, also from detect
        tag = "R11";
        for (int k = 0; k < NK; k++) set_off(k, 0);
        strobes(4);
        set_off(2, 10); strobes(2);
        set_off(0, -30); strobes(3);
        set_off(0, 5); strobes(2);
        set_off(0, 0); strobes(8);

        // pseudo-random interplay
        tag = "R6 random";
        set_cfg(0, 20, 3); set_cfg(1, 9, 0); set_cfg(2, 0, 1);
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < NK; k++) begin
                int r;
                r = rnd(100);
                if (r < 45)      set_off(k, -rnd(35));
                else if (r < 88) set_off(k, -rnd(8));
                else             set_off(k, rnd(9));
            end
            if (rnd(40) == 0) fo = ~fo;
            if (rnd(40) == 0) scope = ~scope;
            if (rnd(30) == 0) maxon = CW'(rnd(5));
            strobes(1);
        end
        cyc(1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R1 flow) actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule